// File: doc/BRIEF.md
# Spline-Driven Waveform Channel

This block is one output channel of a multichannel waveform engine that runs on the DAC sample clock. On every clock it produces one signed 14-bit sample equal to a level term plus an amplitude term times the cosine of a phase term: w = a + b*cos(c). The level `a` and the amplitude `b` are cubic polynomials in the sample count. The phase `c` is a quadratic polynomial. All three are stepped once per clock by forward differencing, so no multiplier sits in the polynomial evaluation.

Software loads the eleven coefficients through an address/data/strobe port into a shadow bank. The running waveform does not change until a trigger word arrives whose bit for this channel is set. A trigger copies every shadow coefficient into the live accumulators at once. One trigger word is shared by all channels, so a single write can restart any subset of them in the same clock. The cosine comes from a quarter-wave table that is computed at elaboration, and the final sum saturates instead of wrapping.

Top module: `waveChannel`

## Requirements
- R1: While reset (`rstN` low) is held and after it is released, the shadow bank, the live accumulators and every pipeline stage are zero, so `dacOut` reads 0 until a trigger loads non-zero coefficients.
- R2: Write address map for `wrAddr` when `wrEn` is high: 0..3 select level terms a0..a3, 4..7 select amplitude terms b0..b3, and 8..10 select phase terms c0..c2. Addresses 11..15 are ignored. A write changes only the shadow bank and has no effect on `dacOut` until the next trigger.
- R3: When `trigValid` is high and `trigMask[CHAN_IDX]` is 1, all eleven shadow values replace the live accumulators in that clock. A trigger without that bit, or a mask with `trigValid` low, leaves the running waveform unchanged.
- R4: Sample n (n = 0, 1, ...) of a newly loaded coefficient set appears on `dacOut` after the (3+n)-th rising edge that follows the edge sampling the trigger. Until then the previous waveform continues.
- R5: The level and amplitude accumulators follow x(n) = x0 + n*x1 + C(n,2)*x2 + C(n,3)*x3 modulo 2^32. Each clock adds term k+1 into term k for all lower terms at the same time, and the highest term holds.
- R6: The phase accumulator follows c(n) = c0 + n*c1 + C(n,2)*c2 modulo 2^32. With c2 = 0 the output frequency is c1/2^32 of the sample rate.
- R7: The level and amplitude values used in a sample are bits 31..16 of their 32-bit accumulators, taken as signed integers.
- R8: The cosine value for phase index p (phase bits 31..22) is round(32767*cos(2*pi*(p+0.5)/1024)). The hardware folds this from a 256-entry quarter table by quadrant.
- R9: The modulated term equals floor(amplitude*cosine / 2^15).
- R10: The sum level + modulated term is clamped to the range -8192..8191 and never wraps.
- R11: Loading all-zero coefficients and triggering gives a constant output of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Shadow coefficient write strobe |
| wrAddr | input | 4 | Coefficient select for the write |
| wrData | input | 32 | Coefficient value |
| trigValid | input | 1 | Trigger word valid |
| trigMask | input | 16 | Per-channel commit mask |
| dacOut | output | 14 | Signed output sample |

## Verification
The assertions assume that reset is asserted before the first trigger, and that `wrAddr` and `trigMask` are stable whenever their strobes are high. The bench drives every input at the falling clock edge with the strobes held for exactly one cycle, which keeps it within those assumptions. The accumulator step checks rely on the highest polynomial term holding between triggers. That holds because triggers are the only path that writes the live state, and the bench only loads through them. The saturation checks assume that amplitude times cosine fits in 17 bits after scaling, which is true for any 16-bit amplitude against a 16-bit cosine.

// File: rtl/wavePkg.sv
package wavePkg;
  localparam int NCOEF = 11;
  localparam int CF_ADDR_W = 4;

  typedef enum logic [CF_ADDR_W-1:0] {
    CF_A0 = 4'd0, CF_A1 = 4'd1, CF_A2 = 4'd2, CF_A3 = 4'd3,
    CF_B0 = 4'd4, CF_B1 = 4'd5, CF_B2 = 4'd6, CF_B3 = 4'd7,
    CF_C0 = 4'd8, CF_C1 = 4'd9, CF_C2 = 4'd10
  } coefAddr_e;

  typedef struct packed {
    logic [NCOEF-1:0] wrSel;
    logic             load;
  } ctrlStb_t;
endpackage

// File: rtl/waveCtrl.sv
module waveCtrl
  import wavePkg::*;
#(
  parameter int CHAN_IDX = 0,
  parameter int MASK_W   = 16
) (
  input  logic                 wrEn,
  input  logic [CF_ADDR_W-1:0] wrAddr,
  input  logic                 trigValid,
  input  logic [MASK_W-1:0]    trigMask,
  output ctrlStb_t             stb
);
  always_comb begin
    for (int k = 0; k < NCOEF; k++) begin
      stb.wrSel[k] = wrEn && (wrAddr == CF_ADDR_W'(k));
    end
    stb.load = trigValid && trigMask[CHAN_IDX];
  end
endmodule

// File: rtl/splineAcc.sv
module splineAcc #(
  parameter int ORDER = 3,
  parameter int W     = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [ORDER:0][W-1:0] seed,
  output logic [W-1:0]       lead,
  output logic [W-1:0]       slope
);
  logic [ORDER:0][W-1:0] term;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      term <= '0;
    end else if (load) begin
      term <= seed;
    end else begin
      for (int k = 0; k < ORDER; k++) begin
        term[k] <= term[k] + term[k+1];
      end
    end
  end

  assign lead  = term[0];
  assign slope = term[1];
endmodule

// File: rtl/cosQuarterLut.sv
module cosQuarterLut #(
  parameter int ABITS = 10,
  parameter int COS_W = 16
) (
  input  logic [ABITS-1:0]        phaseIdx,
  output logic signed [COS_W-1:0] cosVal
);
  localparam int  QBITS   = ABITS - 2;
  localparam int  QUARTER = 1 << QBITS;
  localparam int  FULL    = 1 << ABITS;
  localparam real PEAK    = real'((1 << (COS_W-1)) - 1);
  localparam real TWO_PI  = 6.283185307179586;

  logic [QUARTER-1:0][COS_W-1:0] quarterTab;

  for (genvar gi = 0; gi < QUARTER; gi++) begin : gEntry
    localparam int VAL = $rtoi(PEAK * $cos(TWO_PI * (real'(gi) + 0.5) / real'(FULL)) + 0.5);
    assign quarterTab[gi] = COS_W'(VAL);
  end

  logic [1:0]              quad;
  logic [QBITS-1:0]        rdIdx;
  logic signed [COS_W-1:0] mag;

  always_comb begin
    quad   = phaseIdx[ABITS-1 -: 2];
    rdIdx  = quad[0] ? ~phaseIdx[QBITS-1:0] : phaseIdx[QBITS-1:0];
    mag    = quarterTab[rdIdx];
    cosVal = (quad[1] ^ quad[0]) ? -mag : mag;
  end
endmodule

// File: rtl/waveDatapath.sv
module waveDatapath
  import wavePkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int AMP_W     = 16,
  parameter int COS_W     = 16,
  parameter int LUT_ABITS = 10,
  parameter int OUT_W     = 14,
  parameter int SUM_W     = AMP_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStb_t                stb,
  input  logic [ACC_W-1:0]        wrData,
  output logic signed [OUT_W-1:0] dacOut,
  output logic [ACC_W-1:0]        levelNow,
  output logic [ACC_W-1:0]        levelSlope,
  output logic [ACC_W-1:0]        ampNow,
  output logic [ACC_W-1:0]        ampSlope,
  output logic [ACC_W-1:0]        phaseNow,
  output logic [ACC_W-1:0]        freqNow,
  output logic signed [SUM_W-1:0] sumNow
);
  localparam int PROD_W = AMP_W + COS_W;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = SUM_W'(-(1 << (OUT_W-1)));

  logic [NCOEF-1:0][ACC_W-1:0] shadowReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowReg <= '0;
    end else begin
      for (int k = 0; k < NCOEF; k++) begin
        if (stb.wrSel[k]) shadowReg[k] <= wrData;
      end
    end
  end

  logic [3:0][ACC_W-1:0] levelSeed, ampSeed;
  logic [2:0][ACC_W-1:0] phaseSeed;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      levelSeed[k] = shadowReg[int'(CF_A0) + k];
      ampSeed[k]   = shadowReg[int'(CF_B0) + k];
    end
    for (int k = 0; k < 3; k++) begin
      phaseSeed[k] = shadowReg[int'(CF_C0) + k];
    end
  end

  splineAcc #(.ORDER(3), .W(ACC_W)) uLevel (
    .clk(clk), .rstN(rstN), .load(stb.load), .seed(levelSeed),
    .lead(levelNow), .slope(levelSlope));

  splineAcc #(.ORDER(3), .W(ACC_W)) uAmp (
    .clk(clk), .rstN(rstN), .load(stb.load), .seed(ampSeed),
    .lead(ampNow), .slope(ampSlope));

  splineAcc #(.ORDER(2), .W(ACC_W)) uPhase (
    .clk(clk), .rstN(rstN), .load(stb.load), .seed(phaseSeed),
    .lead(phaseNow), .slope(freqNow));

  logic signed [COS_W-1:0] cosRaw;

  cosQuarterLut #(.ABITS(LUT_ABITS), .COS_W(COS_W)) uCos (
    .phaseIdx(LUT_ABITS'(phaseNow >> (ACC_W - LUT_ABITS))),
    .cosVal(cosRaw));

  logic signed [AMP_W-1:0]  levelS1, ampS1, levelS2;
  logic signed [COS_W-1:0]  cosS1;
  logic signed [PROD_W-1:0] prodFull, prodS2;

  assign prodFull = ampS1 * cosS1;
  assign sumNow   = SUM_W'(levelS2) + SUM_W'(prodS2 >>> (COS_W-1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelS1 <= '0;
      ampS1   <= '0;
      cosS1   <= '0;
      levelS2 <= '0;
      prodS2  <= '0;
      dacOut  <= '0;
    end else begin
      levelS1 <= AMP_W'(levelNow >> (ACC_W - AMP_W));
      ampS1   <= AMP_W'(ampNow >> (ACC_W - AMP_W));
      cosS1   <= cosRaw;
      levelS2 <= levelS1;
      prodS2  <= prodFull;
      if (sumNow > SAT_HI)      dacOut <= SAT_HI[OUT_W-1:0];
      else if (sumNow < SAT_LO) dacOut <= SAT_LO[OUT_W-1:0];
      else                      dacOut <= sumNow[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/waveChannel.sv
module waveChannel
  import wavePkg::*;
#(
  parameter int CHAN_IDX  = 0,
  parameter int MASK_W    = 16,
  parameter int ACC_W     = 32,
  parameter int AMP_W     = 16,
  parameter int COS_W     = 16,
  parameter int LUT_ABITS = 10,
  parameter int OUT_W     = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [CF_ADDR_W-1:0]    wrAddr,
  input  logic [ACC_W-1:0]        wrData,
  input  logic                    trigValid,
  input  logic [MASK_W-1:0]       trigMask,
  output logic signed [OUT_W-1:0] dacOut
);
  localparam int SUM_W = AMP_W + 2;

  ctrlStb_t                stb;
  logic [ACC_W-1:0]        levelNow, levelSlope, ampNow, ampSlope, phaseNow, freqNow;
  logic signed [SUM_W-1:0] sumNow;

  waveCtrl #(.CHAN_IDX(CHAN_IDX), .MASK_W(MASK_W)) uCtrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .trigValid(trigValid),
    .trigMask(trigMask), .stb(stb));

  waveDatapath #(
    .ACC_W(ACC_W), .AMP_W(AMP_W), .COS_W(COS_W),
    .LUT_ABITS(LUT_ABITS), .OUT_W(OUT_W), .SUM_W(SUM_W)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .dacOut(dacOut),
    .levelNow(levelNow), .levelSlope(levelSlope),
    .ampNow(ampNow), .ampSlope(ampSlope),
    .phaseNow(phaseNow), .freqNow(freqNow), .sumNow(sumNow));
endmodule

// File: rtl/waveChannelChk.sv
module waveChannelChk
  import wavePkg::*;
#(
  parameter int CHAN_IDX = 0,
  parameter int MASK_W   = 16,
  parameter int ACC_W    = 32,
  parameter int OUT_W    = 14,
  parameter int SUM_W    = 18
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [CF_ADDR_W-1:0]    wrAddr,
  input logic                    trigValid,
  input logic [MASK_W-1:0]       trigMask,
  input ctrlStb_t                stb,
  input logic [ACC_W-1:0]        levelNow,
  input logic [ACC_W-1:0]        levelSlope,
  input logic [ACC_W-1:0]        ampNow,
  input logic [ACC_W-1:0]        ampSlope,
  input logic [ACC_W-1:0]        phaseNow,
  input logic [ACC_W-1:0]        freqNow,
  input logic signed [SUM_W-1:0] sumNow,
  input logic signed [OUT_W-1:0] dacOut
);
  localparam int OUT_MAX = (1 << (OUT_W-1)) - 1;
  localparam int OUT_MIN = -(1 << (OUT_W-1));

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> dacOut == '0); // R1

  AST_WRSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.wrSel)); // R2

  AST_WRSEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.wrSel) |-> (wrEn && wrAddr < CF_ADDR_W'(NCOEF))); // R2

  AST_LOAD_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (trigValid && trigMask[CHAN_IDX])); // R3

  AST_BIT_GIVES_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (trigValid && trigMask[CHAN_IDX]) |-> stb.load); // R3

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> levelNow == $past(levelNow + levelSlope)); // R5

  AST_AMP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ampNow == $past(ampNow + ampSlope)); // R5

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> phaseNow == $past(phaseNow + freqNow)); // R6

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sumNow > OUT_MAX) |=> dacOut == OUT_W'(OUT_MAX)); // R10

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sumNow < OUT_MIN) |=> dacOut == OUT_W'(OUT_MIN)); // R10

  AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (sumNow <= OUT_MAX && sumNow >= OUT_MIN) |=> dacOut == $past(sumNow[OUT_W-1:0])); // R10
endmodule

bind waveChannel waveChannelChk #(
  .CHAN_IDX(CHAN_IDX), .MASK_W(MASK_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SUM_W(SUM_W)
) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .trigValid(trigValid), .trigMask(trigMask), .stb(stb),
  .levelNow(levelNow), .levelSlope(levelSlope),
  .ampNow(ampNow), .ampSlope(ampSlope),
  .phaseNow(phaseNow), .freqNow(freqNow),
  .sumNow(sumNow), .dacOut(dacOut));

// File: tb/sim_waveChannel.sv
`timescale 1ns/1ps
module sim_waveChannel;
  localparam int CH = 3;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               wrEn = 1'b0;
  logic [3:0]         wrAddr = '0;
  logic [31:0]        wrData = '0;
  logic               trigValid = 1'b0;
  logic [15:0]        trigMask = '0;
  logic signed [13:0] dacOut;

  int  nTests = 0;
  int  nFails = 0;
  bit  done = 1'b0;
  longint shadowM [11];
  longint liveM [11];

  always #2.5 clk = ~clk;

  waveChannel #(.CHAN_IDX(CH)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .trigValid(trigValid), .trigMask(trigMask), .dacOut(dacOut));

  task automatic check(string req, int got, int exp);
    nTests++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Expected sample n of the live set, from closed-form polynomials (R5..R10)
  function automatic int expSample(int n);
    longint nn = n;
    longint b2 = nn * (nn - 1) / 2;
    longint b3 = nn * (nn - 1) * (nn - 2) / 6;
    logic [63:0] aV = liveM[0] + nn*liveM[1] + b2*liveM[2] + b3*liveM[3];
    logic [63:0] bV = liveM[4] + nn*liveM[5] + b2*liveM[6] + b3*liveM[7];
    logic [63:0] cV = liveM[8] + nn*liveM[9] + b2*liveM[10];
    int  aTop = int'($signed(aV[31:16]));
    int  bTop = int'($signed(bV[31:16]));
    int  p    = int'(cV[31:22]);
    real x    = 32767.0 * $cos(6.283185307179586 * (real'(p) + 0.5) / 1024.0);
    int  cv   = (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
    longint prod = (longint'(bTop) * longint'(cv)) >>> 15;
    longint s    = longint'(aTop) + prod;
    if (s > 8191)  s = 8191;
    if (s < -8192) s = -8192;
    return int'(s);
  endfunction

  task automatic writeCoef(int addr, logic [31:0] data);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (addr < 11) shadowM[addr] = longint'($signed(data));
  endtask

  task automatic writeAll(logic [31:0] v [11]);
    for (int k = 0; k < 11; k++) writeCoef(k, v[k]);
  endtask

  task automatic trigger(logic [15:0] mask);
    trigValid = 1'b1; trigMask = mask;
    @(negedge clk);
    trigValid = 1'b0; trigMask = '0;
    if (mask[CH]) liveM = shadowM;
  endtask

  task automatic checkRun(int n, string req);
    repeat (2) @(posedge clk);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      check(req, int'(dacOut), expSample(k));
    end
  endtask

  task automatic checkHold(int n, int val, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(req, int'(dacOut), val);
    end
  endtask

  initial begin
    logic [31:0] zeroSet [11];
    logic [31:0] cfg [11];
    for (int k = 0; k < 11; k++) begin
      zeroSet[k] = '0; shadowM[k] = 0; liveM[k] = 0;
    end

    // R1: reset state
    repeat (3) begin @(negedge clk); check("R1 during reset", int'(dacOut), 0); end
    rstN = 1'b1;
    checkHold(3, 0, "R1 after reset");
    trigger(16'hFFFF);
    checkRun(6, "R1 cleared shadow");

    // R2: writes alone do not reach the output
    writeCoef(0, 32'(1000 << 16));
    checkHold(6, 0, "R2 write without trigger");

    // R7: constant level
    trigger(16'(1 << CH));
    checkRun(10, "R7 constant level");

    // R4: exact latency from old to new set
    writeCoef(0, 32'(-500 <<< 16));
    trigger(16'(1 << CH));
    @(posedge clk); @(negedge clk); check("R4 edge1 old", int'(dacOut), 1000);
    @(posedge clk); @(negedge clk); check("R4 edge2 old", int'(dacOut), 1000);
    @(posedge clk); @(negedge clk); check("R4 edge3 new", int'(dacOut), -500);

    // R3: other mask bits and a dropped valid do not commit
    writeCoef(0, 32'(2000 << 16));
    trigger(~16'(1 << CH));
    checkHold(6, -500, "R3 other bits");
    trigMask = 16'(1 << CH);
    @(negedge clk);
    trigMask = '0;
    checkHold(5, -500, "R3 mask without valid");
    // R2: addresses 11..15 are ignored
    for (int a = 11; a < 16; a++) writeCoef(a, 32'h7FFF_FFFF);
    trigger(16'(1 << CH));
    checkRun(8, "R3 commit and R2 ignored addresses");

    // R5: cubic level
    cfg = zeroSet;
    cfg[0] = 32'(100 << 16); cfg[1] = 32'(3 << 14);
    cfg[2] = 32'(-(1 << 10)); cfg[3] = 32'd7;
    writeAll(cfg);
    trigger(16'hFFFF);
    checkRun(60, "R5 cubic level");

    // R8: exhaustive phase sweep, one table entry per sample
    cfg = zeroSet;
    cfg[4] = 32'(8000 << 16); cfg[9] = 32'(1 << 22);
    writeAll(cfg);
    trigger(16'(1 << CH));
    checkRun(1024, "R8 cosine sweep");

    // R9: fixed tone with level offset and ramped amplitude
    cfg = zeroSet;
    cfg[0] = 32'(-300 <<< 16); cfg[4] = 32'(4000 << 16); cfg[5] = 32'(20 << 16);
    cfg[8] = 32'h4000_0000; cfg[9] = 32'h147A_E148;
    writeAll(cfg);
    trigger(16'(1 << CH));
    checkRun(64, "R9 scaled tone");

    // R6: quadratic phase chirp
    cfg = zeroSet;
    cfg[4] = 32'(6000 << 16); cfg[9] = 32'h0100_0000; cfg[10] = 32'h0010_0000;
    writeAll(cfg);
    trigger(16'(1 << CH));
    checkRun(100, "R6 chirp");

    // R10: full-scale amplitude against cosine saturates both ways
    cfg = zeroSet;
    cfg[4] = 32'h8000_0000; cfg[9] = 32'(3 << 22);
    writeAll(cfg);
    trigger(16'(1 << CH));
    checkRun(400, "R10 full scale");

    // R10: level sweep around both clamp points
    writeAll(zeroSet);
    for (int v = 8185; v <= 8198; v++) begin
      for (int sgn = 0; sgn < 2; sgn++) begin
        int lv = sgn ? -v : v;
        writeCoef(0, 32'(lv <<< 16));
        trigger(16'(1 << CH));
        checkRun(1, "R10 clamp sweep");
      end
    end

    // R11: all-zero load
    cfg = zeroSet;
    cfg[0] = 32'(1234 << 16); cfg[4] = 32'(900 << 16); cfg[9] = 32'h0200_0000;
    writeAll(cfg);
    trigger(16'(1 << CH));
    checkRun(5, "R11 before zero load");
    writeAll(zeroSet);
    trigger(16'hFFFF);
    checkRun(20, "R11 zero load");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nTests++; nFails++;
      $display("FAIL watchdog R1..: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule